// File: doc/BRIEF.md
# Systolic FIR Tap Slice with Symmetric Pre-Adder

This block is a single multiply-accumulate tap meant to be cascaded into a systolic FIR filter. Each slice receives a travelling sample and hands it on to its neighbour through two registers. It can also take a mirror sample from the far end of the delay line. It adds the two samples in a pre-adder, multiplies the sum by a locally held coefficient, and adds the product to the partial sum arriving from the previous slice. The sample path, the products and the partial sum advance only on a sample strobe.

The coefficient sits in a register that loads from a daisy chain on a load strobe. Its value is driven out again to feed the next slice toward the start of the chain. A filter of K slices is built by wiring each slice's forwarded sample and partial sum into the next slice. The coefficient forward output of each slice is wired into the previous slice. The mirror input of every slice is fed with the input stream delayed by 2K-1 accepted samples, which gives a symmetric filter of 2K taps. When the `FOLD` parameter is 0, the mirror input is not built and the slice is a plain K-tap stage.

Top module: `fir_tap_slice`

## Requirements
- R1: A cycle with `rst` or `clr` high zeroes every sample, pre-add, product and sum register. After it, `smp_fwd` and `psum_out` read 0, and the first three accepted samples that follow add nothing to `psum_in`. `rst` also sets the coefficient to `RESET_COEF`.
- R2: `clr` leaves the coefficient register and `cf_fwd` unchanged.
- R3: While `smp_stb` is low and neither `rst` nor `clr` is high, `smp_fwd` and `psum_out` keep their values.
- R4: Number the accepted samples from 0 after the last reset or clear. After accepted sample n, `smp_fwd` equals the `smp_a` accepted at sample n-1, or 0 when n is 0.
- R5: When `cf_ld` is high at an edge, `cf_fwd` takes the value of `cf_in`. Otherwise it holds. This is independent of `smp_stb`.
- R6: After accepted sample n, `psum_out` equals the `psum_in` present at that edge plus C×(a[n-3]+b[n-3]). Here a and b are the accepted `smp_a` and `smp_b` values, taken as 0 for negative indices. C is the coefficient held when sample n-1 was accepted.
- R7: All operands are two's complement. The pre-add is one bit wider than the samples and never overflows. The product is sign-extended, and the partial sum wraps modulo 2^AW without saturation.
- R8: With `FOLD` = 0, `smp_b` has no effect on `psum_out`, which becomes `psum_in` plus C×a[n-3].
- R9: K cascaded slices, with every mirror input fed by the input delayed 2K-1 accepted samples, produce y(n) = Σ c_i·(x[n-K-2-i] + x[n-3K-1+i]) at the last slice's `psum_out`. Here c_i is the coefficient held by slice i.
- R10: After K load strobes with values v1..vK entering at slice K-1, slice j holds v(j+1). The first value loaded ends in slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset: pipeline zeroed, coefficient set to RESET_COEF |
| clr | input | 1 | Synchronous clear: pipeline zeroed, coefficient kept |
| smp_stb | input | 1 | Sample accepted this cycle; advances the whole sample pipeline |
| smp_a | input | SW | Travelling sample from the previous slice |
| smp_b | input | SW | Mirror sample for symmetric folding |
| smp_fwd | output | SW | Travelling sample for the next slice, two registers late |
| cf_ld | input | 1 | Coefficient load strobe |
| cf_in | input | CW | Coefficient chain input from the neighbour further down |
| cf_fwd | output | CW | Held coefficient, passed to the neighbour toward slice 0 |
| psum_in | input | AW | Partial sum from the previous slice |
| psum_out | output | AW | Registered partial sum for the next slice |

## Verification
The assertions assume that `rst` is high from time zero until at least one clock edge has passed. They assume that `smp_a`, `smp_b`, `cf_in` and `psum_in` are never unknown at an edge. They also assume that every input changes only between edges. The bench holds reset from the first cycle and drives every input from its first cycle. It changes inputs on the falling edge and samples results one nanosecond after the rising edge. Coefficients are reloaded either while the stream is paused or together with a strobe. In both cases the coefficient that applies is the one held when a sample was accepted, and the bench model tracks that value per strobe.

// File: rtl/fir_tap_pkg.sv
package fir_tap_pkg;

  typedef enum logic [1:0] {
    TAP_IDLE    = 2'd0,
    TAP_ADVANCE = 2'd1,
    TAP_FLUSH   = 2'd2
  } tap_op_e;

  // Flush dominates advance; otherwise the pipeline holds.
  function automatic tap_op_e pick_op(input logic rst_i, input logic clr_i,
                                      input logic adv_i);
    if (rst_i || clr_i) return TAP_FLUSH;
    if (adv_i)          return TAP_ADVANCE;
    return TAP_IDLE;
  endfunction

endpackage

// File: rtl/fir_tap_sample_path.sv
module fir_tap_sample_path
  import fir_tap_pkg::*;
#(
  parameter int SW   = 16,
  parameter int FOLD = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [SW-1:0] a_in,
  input  logic [SW-1:0] b_in,
  output logic [SW-1:0] a_stage,
  output logic [SW-1:0] b_stage,
  output logic [SW-1:0] fwd
);

  tap_op_e       op;
  logic [SW-1:0] a0_q;
  logic [SW-1:0] a1_q;

  assign op = pick_op(rst, clr, adv);

  always_ff @(posedge clk) begin
    case (op)
      TAP_FLUSH: begin
        a0_q <= '0;
        a1_q <= '0;
      end
      TAP_ADVANCE: begin
        a0_q <= a_in;
        a1_q <= a0_q;
      end
      default: begin
        a0_q <= a0_q;
        a1_q <= a1_q;
      end
    endcase
  end

  generate
    if (FOLD != 0) begin : g_fold
      logic [SW-1:0] b0_q;
      always_ff @(posedge clk) begin
        case (op)
          TAP_FLUSH:   b0_q <= '0;
          TAP_ADVANCE: b0_q <= b_in;
          default:     b0_q <= b0_q;
        endcase
      end
      assign b_stage = b0_q;
    end else begin : g_nofold
      logic unused_b;
      assign unused_b = ^b_in;
      assign b_stage  = '0;
    end
  endgenerate

  assign a_stage = a0_q;
  assign fwd     = a1_q;

  AST_FLUSH_FWD: assert property (@(posedge clk) disable iff (1'b0)
    (rst || clr) |=> (fwd == '0 && a_stage == '0)); // R1

  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
    !adv |=> $stable(fwd)); // R3

  AST_FWD_TWO_STAGE: assert property (@(posedge clk) disable iff (rst || clr)
    adv ##1 adv |=> fwd == $past(a_in, 2)); // R4

endmodule

// File: rtl/fir_tap_coef_reg.sv
module fir_tap_coef_reg #(
  parameter int              CW         = 16,
  parameter logic [CW-1:0]   RESET_COEF = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] cf_in,
  output logic [CW-1:0] coef
);

  logic [CW-1:0] coef_q;

  always_ff @(posedge clk) begin
    if (rst)     coef_q <= RESET_COEF;
    else if (ld) coef_q <= cf_in;
    else         coef_q <= coef_q;
  end

  assign coef = coef_q;

  AST_COEF_RESET: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> coef == RESET_COEF); // R1

  AST_COEF_TAKE: assert property (@(posedge clk) disable iff (rst)
    ld |=> coef == $past(cf_in)); // R5

  AST_COEF_KEEP: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(coef)); // R2

endmodule

// File: rtl/fir_tap_mac.sv
module fir_tap_mac
  import fir_tap_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [SW-1:0] a_stage,
  input  logic [SW-1:0] b_stage,
  input  logic [CW-1:0] coef,
  input  logic [AW-1:0] psum_in,
  output logic [AW-1:0] psum_out
);

  localparam int PW = SW + 1;
  localparam int MW = PW + CW;

  // Pre-add with one guard bit: exact for any pair of samples.
  function automatic logic signed [PW-1:0] fold_add(input logic [SW-1:0] x,
                                                    input logic [SW-1:0] y);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ye;
    xe = {x[SW-1], x};
    ye = {y[SW-1], y};
    return xe + ye;
  endfunction

  // Full-precision signed product of pre-add sum and coefficient.
  function automatic logic signed [MW-1:0] tap_mul(input logic signed [PW-1:0] p,
                                                   input logic [CW-1:0] c);
    logic signed [MW-1:0] pe;
    logic signed [MW-1:0] ce;
    pe = {{CW{p[PW-1]}}, p};
    ce = {{PW{c[CW-1]}}, c};
    return pe * ce;
  endfunction

  // Sign-extend the product and add, wrapping modulo 2^AW.
  function automatic logic [AW-1:0] acc_step(input logic [AW-1:0] s,
                                             input logic signed [MW-1:0] m);
    logic [AW-1:0] me;
    me = AW'(m);
    return s + me;
  endfunction

  tap_op_e              op;
  logic signed [PW-1:0] pre_q;
  logic signed [MW-1:0] prod_q;
  logic [AW-1:0]        acc_q;

  assign op = pick_op(rst, clr, adv);

  always_ff @(posedge clk) begin
    case (op)
      TAP_FLUSH: begin
        pre_q  <= '0;
        prod_q <= '0;
        acc_q  <= '0;
      end
      TAP_ADVANCE: begin
        pre_q  <= fold_add(a_stage, b_stage);
        prod_q <= tap_mul(pre_q, coef);
        acc_q  <= acc_step(psum_in, prod_q);
      end
      default: begin
        pre_q  <= pre_q;
        prod_q <= prod_q;
        acc_q  <= acc_q;
      end
    endcase
  end

  assign psum_out = acc_q;

  AST_SUM_FLUSH: assert property (@(posedge clk) disable iff (1'b0)
    (rst || clr) |=> psum_out == '0); // R1

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
    !adv |=> $stable(psum_out)); // R3

  AST_PRE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst || clr)
    adv |=> (pre_q[PW-1] == pre_q[PW-2]) || ($past(a_stage[SW-1]) == $past(b_stage[SW-1]))); // R7

endmodule

// File: rtl/fir_tap_slice.sv
module fir_tap_slice
  import fir_tap_pkg::*;
#(
  parameter int            SW         = 16,
  parameter int            CW         = 16,
  parameter int            AW         = 40,
  parameter int            FOLD       = 1,
  parameter logic [CW-1:0] RESET_COEF = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          smp_stb,
  input  logic [SW-1:0] smp_a,
  input  logic [SW-1:0] smp_b,
  output logic [SW-1:0] smp_fwd,
  input  logic          cf_ld,
  input  logic [CW-1:0] cf_in,
  output logic [CW-1:0] cf_fwd,
  input  logic [AW-1:0] psum_in,
  output logic [AW-1:0] psum_out
);

  // Named events shared by the stages and their assertions.
  logic          adv_evt;
  logic          flush_evt;
  logic          load_evt;
  logic [SW-1:0] a_stage;
  logic [SW-1:0] b_stage;
  logic [CW-1:0] coef_now;

  assign adv_evt   = smp_stb;
  assign flush_evt = rst | clr;
  assign load_evt  = cf_ld;

  fir_tap_sample_path #(.SW(SW), .FOLD(FOLD)) u_path (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .adv     (adv_evt),
    .a_in    (smp_a),
    .b_in    (smp_b),
    .a_stage (a_stage),
    .b_stage (b_stage),
    .fwd     (smp_fwd)
  );

  fir_tap_coef_reg #(.CW(CW), .RESET_COEF(RESET_COEF)) u_coef (
    .clk   (clk),
    .rst   (rst),
    .ld    (load_evt),
    .cf_in (cf_in),
    .coef  (coef_now)
  );

  fir_tap_mac #(.SW(SW), .CW(CW), .AW(AW)) u_mac (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .adv      (adv_evt),
    .a_stage  (a_stage),
    .b_stage  (b_stage),
    .coef     (coef_now),
    .psum_in  (psum_in),
    .psum_out (psum_out)
  );

  assign cf_fwd = coef_now;

  AST_CLEAR_KEEPS_COEF: assert property (@(posedge clk) disable iff (rst)
    (clr && !load_evt) |=> $stable(cf_fwd)); // R2

  AST_FLUSH_OUTPUTS: assert property (@(posedge clk) disable iff (1'b0)
    flush_evt |=> (psum_out == '0 && smp_fwd == '0)); // R1

  AST_FIRST_SUM_PASS: assert property (@(posedge clk) disable iff (rst || clr)
    ($past(flush_evt) && adv_evt) |=> psum_out == $past(psum_in)); // R1

endmodule

// File: tb/fir_tap_slice_tb.sv
module fir_tap_slice_tb;
  localparam int SW = 6;
  localparam int CW = 6;
  localparam int AW = 16;
  localparam int K  = 4;
  localparam int RC = 5;
  localparam int HN = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, clr = 1'b0, stb = 1'b0, ld = 1'b0;
  logic [SW-1:0] a = '0, b = '0;
  logic [CW-1:0] cin = '0;
  logic [AW-1:0] pin = '0;
  logic [SW-1:0] fwd, nf_fwd;
  logic [CW-1:0] cf, nf_cf;
  logic [AW-1:0] sum, nf_sum;

  fir_tap_slice #(.SW(SW), .CW(CW), .AW(AW), .FOLD(1), .RESET_COEF(CW'(RC))) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .smp_stb(stb), .smp_a(a), .smp_b(b),
    .smp_fwd(fwd), .cf_ld(ld), .cf_in(cin), .cf_fwd(cf),
    .psum_in(pin), .psum_out(sum));

  fir_tap_slice #(.SW(SW), .CW(CW), .AW(AW), .FOLD(0), .RESET_COEF(CW'(RC))) u_nofold (
    .clk(clk), .rst(rst), .clr(clr), .smp_stb(stb), .smp_a(a), .smp_b(b),
    .smp_fwd(nf_fwd), .cf_ld(ld), .cf_in(cin), .cf_fwd(nf_cf),
    .psum_in(pin), .psum_out(nf_sum));

  // Cascade for the filter-level checks
  logic          ch_stb = 1'b0, ch_ld = 1'b0;
  logic [SW-1:0] ch_x = '0, ch_b = '0;
  logic [CW-1:0] ch_cin = '0;
  logic [SW-1:0] c_a  [0:K];
  logic [CW-1:0] c_cf [0:K];
  logic [AW-1:0] c_sum[0:K];
  assign c_a[0]   = ch_x;
  assign c_cf[K]  = ch_cin;
  assign c_sum[0] = '0;

  for (genvar g = 0; g < K; g++) begin : g_chain
    fir_tap_slice #(.SW(SW), .CW(CW), .AW(AW), .FOLD(1), .RESET_COEF(CW'(RC))) u_tap (
      .clk(clk), .rst(rst), .clr(clr), .smp_stb(ch_stb), .smp_a(c_a[g]), .smp_b(ch_b),
      .smp_fwd(c_a[g+1]), .cf_ld(ch_ld), .cf_in(c_cf[g+1]), .cf_fwd(c_cf[g]),
      .psum_in(c_sum[g]), .psum_out(c_sum[g+1]));
  end

  int errors = 0, checks = 0;
  bit done = 0;

  // Model state for the single slice
  int ah[0:HN-1], bh[0:HN-1], chh[0:HN-1];
  int n = 0, mc = RC;
  int exp_sum = 0, exp_nf = 0, exp_fwd = 0;

  function automatic int sx(input int v, input int w);
    int m;
    m = v & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  function automatic int msk(input int v, input int w);
    return v & ((1 << w) - 1);
  endfunction

  task automatic chk(input string tag, input int act, input int expv, input int w);
    checks++;
    if (act != msk(expv, w)) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, msk(expv, w));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; stb = 1'b0; ld = 1'b0;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    n = 0; mc = RC; exp_sum = 0; exp_nf = 0; exp_fwd = 0;
    #1;
    chk("R1 reset sum", int'(sum), 0, AW);
    chk("R1 reset fwd", int'(fwd), 0, SW);
    chk("R1 reset coef", int'(cf), RC, CW);
  endtask

  // One cycle of stimulus on the single slices, then check at edge+1ns
  task automatic cyc(input bit s, input int av, input int bv, input int pv,
                     input bit l, input int cv, input bit c);
    int va, vb, vp;
    @(negedge clk);
    stb = s; a = av[SW-1:0]; b = bv[SW-1:0]; pin = pv[AW-1:0];
    ld = l; cin = cv[CW-1:0]; clr = c;
    @(posedge clk); #1;
    clr = 1'b0;
    if (c) begin
      n = 0; exp_sum = 0; exp_nf = 0; exp_fwd = 0;
    end else if (s) begin
      va = sx(av, SW); vb = sx(bv, SW); vp = sx(pv, AW);
      ah[n] = va; bh[n] = vb; chh[n] = mc;
      if (n >= 3) begin
        exp_sum = vp + chh[n-1] * (ah[n-3] + bh[n-3]);
        exp_nf  = vp + chh[n-1] * ah[n-3];
      end else begin
        exp_sum = vp;
        exp_nf  = vp;
      end
      exp_fwd = (n >= 1) ? ah[n-1] : 0;
      n++;
    end
    if (l) mc = sx(cv, CW);
    if (c) begin
      chk("R1 clear sum", int'(sum), 0, AW);
      chk("R1 clear fwd", int'(fwd), 0, SW);
      chk("R2 clear keeps coef", int'(cf), mc, CW);
    end else begin
      chk(s ? "R6 sum" : "R3 sum hold", int'(sum), exp_sum, AW);
      chk(s ? "R4 fwd" : "R3 fwd hold", int'(fwd), exp_fwd, SW);
      chk("R5 coef", int'(cf), mc, CW);
      chk("R8 nofold sum", int'(nf_sum), exp_nf, AW);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  int cset[0:3] = '{-32, -7, 1, 31};
  int xh[0:HN-1];
  int cc[0:K-1] = '{3, -5, 11, -2};

  initial begin
    do_reset();

    // R5: load while stream paused, and load together with a strobe
    cyc(0, 0, 0, 0, 1, 9, 0);
    cyc(1, 3, 4, 100, 1, -4, 0);

    // Near-exhaustive sweep: every sample value, several coefficients
    for (int ci = 0; ci < 4; ci++) begin
      cyc(0, 0, 0, 0, 1, cset[ci], 1);
      for (int av = -32; av < 32; av++) begin
        cyc(((av + 40) % 5) != 0, av, av * 5 + 3, av * 311 - 77, 0, 0, 0);
      end
    end

    // R7: extreme operands, exact pre-add and wrapping accumulator
    cyc(0, 0, 0, 0, 1, -32, 1);
    for (int k = 0; k < 6; k++) cyc(1, -32, -32, 32767, 0, 0, 0);
    chk("R7 wrap", int'(sum), 32767 + (-32) * (-64), AW);
    for (int k = 0; k < 4; k++) cyc(1, 31, 31, -32768, 0, 0, 0);
    chk("R7 negative wrap", int'(sum), -32768 + (-32) * 62, AW);

    // R1: first three samples after clear add nothing
    cyc(0, 0, 0, 0, 1, 7, 1);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 20, -9, 1000 + k, 0, 0, 0);
      chk("R1 empty pipe", int'(sum), 1000 + k, AW);
    end

    // Reset restores RESET_COEF
    do_reset();

    // Cascade: load coefficients, first value lands in slice 0
    for (int g = 0; g < K; g++) begin
      @(negedge clk); ch_ld = 1'b1; ch_cin = cc[g][CW-1:0];
    end
    @(negedge clk); ch_ld = 1'b0;
    for (int g = 0; g < K; g++) chk("R10 chain coef", int'(c_cf[g]), cc[g], CW);

    // Cascade: stream with pauses, mirror input delayed 2K-1 samples
    for (int m = 0, cyc_i = 0; m < 80; cyc_i++) begin
      int y, xv;
      bit s;
      s = (cyc_i % 7) != 3;
      xv = sx(m * 13 + (m / 3) * 7 - 20, SW);
      @(negedge clk);
      ch_stb = s;
      ch_x = xv[SW-1:0];
      ch_b = (m >= 2*K-1) ? xh[m-(2*K-1)][SW-1:0] : '0;
      @(posedge clk); #1;
      if (s) begin
        xh[m] = xv;
        y = 0;
        for (int i = 0; i < K; i++) begin
          int j1, j2;
          j1 = m - K - 2 - i;
          j2 = m - 3*K - 1 + i;
          y += cc[i] * (((j1 >= 0) ? xh[j1] : 0) + ((j2 >= 0) ? xh[j2] : 0));
        end
        chk("R9 symmetric fir", int'(c_sum[K]), y, AW);
        m++;
      end
    end
    @(negedge clk); ch_stb = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule